// File: doc/BRIEF.md
# Serial FIFO extension controller

This block widens a plain byte-stream serial core with two deep FIFOs, one for receive and one for transmit, and with a small bank of control registers. A host reaches it through a 4-bit address, an 8-bit data bus and separate read and write strobes. The lower eight addresses hold the extension registers: mode, interrupt enable, status with a FIFO-flush strobe, timer interval and timer control. The upper eight pass through to the serial core's own 16550-style registers. When the FIFOs are enabled, the core's data register is taken over: host reads pop the receive FIFO and host writes push the transmit FIFO. The core itself moves bytes in and out over ready/valid ports.

Five interrupt sources are merged into one output: receive half full, character time-out, transmit empty, transmit half full and an external interval-timer request. Each source has its own clear rule, tied to FIFO reads, FIFO writes, status reads or a timer-control write. The output is either a level or a one-cycle pulse on each rising edge of the merged request. A mode bit can swap the two 8-byte halves of the address window.

Top module: `sfx_ctrl`

## Requirements
- R1: After reset the mode, interrupt-enable and timer registers read 0, the status register reads 0x29, irq_out is 0, rx_ready is 0 and tx_valid is 0.
- R2: The mode register at offset 0 keeps bits 4 (1 = level interrupt), 3 (automatic RTS/CTS), 2 (FIFO enable) and 0 (window swap). Bit 1 and bits 7:5 always read 0.
- R3: Host accesses at offsets 8 to 15 reach core register offset 0 to 7 through core_addr, core_wr, core_rd and core_rdata. With FIFOs disabled this includes offset 8.
- R4: With FIFOs enabled, a host read of offset 8 returns the oldest receive byte and pops it, and a host write of offset 8 pushes the transmit FIFO. Bytes leave on tx_data in write order. A core push and a host pop of the receive FIFO in the same cycle both take effect.
- R5: While inhibit_rx is 1, rx_ready is 0. While inhibit_tx is 1, tx_valid is 0.
- R6: With mode bit 0 set, host offsets 0 to 7 reach the core registers and offsets 8 to 15 reach the extension registers.
- R7: Any write to offset 2 empties both FIFOs, and the next status read shows both empty.
- R8: The status register has these bits: 7 timer pending, 6 time-out pending, 5 receive not-full (0 means full), 4 receive at least half (128 of 256), 3 receive empty, 2 transmit full, 1 transmit at least half, 0 transmit empty. The receive-half source follows bit 4, so it clears once reads take the count below 128.
- R9: A non-empty receive FIFO that sees no push and no pop for CTO_CYCLES clocks raises time-out pending. A status read or a receive pop clears it.
- R10: A core pop that empties the transmit FIFO raises transmit-empty pending. A transmit write or a status read clears it.
- R11: A core pop that takes the transmit count from 128 to 127 raises transmit-half pending. A write that brings the count back to 128 or more, or a status read, clears it.
- R12: Offsets 3 and 4 hold the timer interval and enable, driven on tmr_interval and tmr_enable. timer_irq while enabled sets timer pending, and writing enable = 0 clears it.
- R13: Interrupt-enable bits are 4 timer, 3 time-out, 2 transmit empty, 1 transmit half, 0 receive half. In level mode irq_out is the OR of enabled pending sources, one clock late. In edge mode irq_out is a single-cycle pulse when that OR rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops FIFO / clears on read) |
| host_rdata | output | 8 | Host read data, valid in the strobe cycle |
| irq_out | output | 1 | Merged interrupt request |
| core_addr | output | 3 | Core register offset |
| core_wdata | output | 8 | Core register write data |
| core_wr | output | 1 | Core register write strobe |
| core_rd | output | 1 | Core register read strobe |
| core_rdata | input | 8 | Core register read data |
| rx_valid | input | 1 | Core offers a received byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Receive FIFO accepts the byte |
| tx_valid | output | 1 | Transmit FIFO offers a byte |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Core takes the byte |
| inhibit_rx | input | 1 | Stop core-to-FIFO receive transfer |
| inhibit_tx | input | 1 | Stop FIFO-to-core transmit transfer |
| timer_irq | input | 1 | Request from the external interval timer |
| tmr_interval | output | 8 | Timer interval register |
| tmr_enable | output | 1 | Timer enable |
| flow_auto | output | 1 | Automatic RTS/CTS enable for the core |

## Verification
The receive FIFO can be pushed by the core and popped by the host in the same clock. This is the one point where two independent agents touch the same count. The bench raises rx_valid in the same cycle as a host read of the data register. It checks that the returned byte is the old head, that rx_ready stayed high, and that the pushed byte comes out after the remaining queued bytes, with the FIFO empty afterwards. A scoreboard queue on each side judges ordering across all tests.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  // extension register offsets (within the lower 8-byte half)
  localparam logic [2:0] OFF_MODE = 3'd0;
  localparam logic [2:0] OFF_IER  = 3'd1;
  localparam logic [2:0] OFF_STAT = 3'd2;
  localparam logic [2:0] OFF_TIVL = 3'd3;
  localparam logic [2:0] OFF_TCTL = 3'd4;
  // mode bit positions
  localparam int MODE_SWAP  = 0;
  localparam int MODE_FIFO  = 2;
  localparam int MODE_FLOW  = 3;
  localparam int MODE_LEVEL = 4;
  localparam logic [7:0] MODE_WMASK = 8'h1D;
  localparam logic [7:0] IER_WMASK  = 8'h1F;
  // pending vector order, aligned with the enable register
  localparam int SRC_RXH = 0;
  localparam int SRC_TXH = 1;
  localparam int SRC_TXE = 2;
  localparam int SRC_CTO = 3;
  localparam int SRC_TMR = 4;
  localparam int NSRC    = 5;
endpackage

// File: rtl/sfx_fifo.sv
module sfx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 256   // power of two
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     push,
  input  logic [W-1:0]             din,
  input  logic                     pop,
  output logic [W-1:0]             dout,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     empty,
  output logic                     full,
  output logic                     pushed,
  output logic                     popped
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CW'(DEPTH));
  assign pushed = push && !full && !flush;
  assign popped = pop && !empty && !flush;
  assign count  = cnt_q;
  assign dout   = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (pushed) wp_d = wp_q + 1'b1;
      if (popped) rp_d = rp_q + 1'b1;
      if (pushed && !popped)      cnt_d = cnt_q + 1'b1;
      else if (!pushed && popped) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pushed) mem[wp_q] <= din;
  end
endmodule

// File: rtl/sfx_irq.sv
module sfx_irq
  import sfx_pkg::*;
#(
  parameter int DEPTH      = 256,
  parameter int CTO_CYCLES = 4096
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [$clog2(DEPTH):0] rx_cnt,
  input  logic                   rx_pushed,
  input  logic                   rx_popped,
  input  logic [$clog2(DEPTH):0] tx_cnt,
  input  logic                   tx_pushed,
  input  logic                   tx_popped,
  input  logic                   flush,
  input  logic                   stat_rd,
  input  logic                   timer_irq,
  input  logic                   tmr_en,
  input  logic                   tmr_off,
  input  logic [NSRC-1:0]        ier,
  input  logic                   level_mode,
  output logic [NSRC-1:0]        pend,
  output logic                   irq_out
);
  localparam int CW   = $clog2(DEPTH) + 1;
  localparam int HALF = DEPTH / 2;
  localparam int TW   = $clog2(CTO_CYCLES + 1);

  logic [TW-1:0] idle_q, idle_d;
  logic cto_q, cto_d, txe_q, txe_d, txh_q, txh_d, tmr_q, tmr_d;
  logic any_req, any_q, irq_q, irq_d;
  logic cto_fire, txe_fire, txh_fire, txh_clr;

  // idle counter: saturates, so time-out fires once per quiet period
  always_comb begin
    idle_d = idle_q;
    if (flush || rx_cnt == '0 || rx_pushed || rx_popped) idle_d = '0;
    else if (idle_q != TW'(CTO_CYCLES))                 idle_d = idle_q + 1'b1;
  end
  assign cto_fire = (idle_d == TW'(CTO_CYCLES)) && (idle_q != TW'(CTO_CYCLES));
  assign txe_fire = tx_popped && !tx_pushed && (tx_cnt == CW'(1));
  assign txh_fire = tx_popped && !tx_pushed && (tx_cnt == CW'(HALF));
  assign txh_clr  = stat_rd || (tx_pushed && !tx_popped && tx_cnt >= CW'(HALF - 1));

  // a new event in the same cycle as its clear wins
  always_comb begin
    cto_d = cto_fire ? 1'b1 : ((rx_popped || stat_rd || flush) ? 1'b0 : cto_q);
    txe_d = txe_fire ? 1'b1 : ((tx_pushed || stat_rd) ? 1'b0 : txe_q);
    txh_d = txh_fire ? 1'b1 : (txh_clr ? 1'b0 : txh_q);
    tmr_d = (timer_irq && tmr_en) ? 1'b1 : (tmr_off ? 1'b0 : tmr_q);
  end

  always_comb begin
    pend          = '0;
    pend[SRC_RXH] = (rx_cnt >= CW'(HALF));
    pend[SRC_TXH] = txh_q;
    pend[SRC_TXE] = txe_q;
    pend[SRC_CTO] = cto_q;
    pend[SRC_TMR] = tmr_q;
  end

  assign any_req = |(pend & ier);
  assign irq_d   = level_mode ? any_req : (any_req && !any_q);
  assign irq_out = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
      cto_q  <= 1'b0;
      txe_q  <= 1'b0;
      txh_q  <= 1'b0;
      tmr_q  <= 1'b0;
      any_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      idle_q <= idle_d;
      cto_q  <= cto_d;
      txe_q  <= txe_d;
      txh_q  <= txh_d;
      tmr_q  <= tmr_d;
      any_q  <= any_req;
      irq_q  <= irq_d;
    end
  end
endmodule

// File: rtl/sfx_ctrl.sv
module sfx_ctrl
  import sfx_pkg::*;
#(
  parameter int DEPTH      = 256,
  parameter int CTO_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] host_addr,
  input  logic [7:0] host_wdata,
  input  logic       host_wr,
  input  logic       host_rd,
  output logic [7:0] host_rdata,
  output logic       irq_out,
  output logic [2:0] core_addr,
  output logic [7:0] core_wdata,
  output logic       core_wr,
  output logic       core_rd,
  input  logic [7:0] core_rdata,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  input  logic       inhibit_rx,
  input  logic       inhibit_tx,
  input  logic       timer_irq,
  output logic [7:0] tmr_interval,
  output logic       tmr_enable,
  output logic       flow_auto
);
  localparam int CW   = $clog2(DEPTH) + 1;
  localparam int HALF = DEPTH / 2;

  // reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ni <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ni <= rst_s1;
    end
  end

  logic [7:0] mode_q, mode_d, ier_q, ier_d, tivl_q, tivl_d;
  logic       tctl_q, tctl_d;

  // address decode after optional half swap
  logic [3:0] eff;
  logic [2:0] sub;
  logic core_sel, data_fifo, ext_wr, ext_rd, flush, stat_rd, tmr_off;
  assign eff       = host_addr ^ {mode_q[MODE_SWAP], 3'b000};
  assign sub       = eff[2:0];
  assign core_sel  = eff[3];
  assign data_fifo = core_sel && (sub == 3'd0) && mode_q[MODE_FIFO];
  assign ext_wr    = host_wr && !core_sel;
  assign ext_rd    = host_rd && !core_sel;
  assign flush     = ext_wr && (sub == OFF_STAT);
  assign stat_rd   = ext_rd && (sub == OFF_STAT);
  assign tmr_off   = ext_wr && (sub == OFF_TCTL) && !host_wdata[0];

  assign core_addr  = sub;
  assign core_wdata = host_wdata;
  assign core_wr    = host_wr && core_sel && !data_fifo;
  assign core_rd    = host_rd && core_sel && !data_fifo;

  // FIFOs
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic rx_empty, rx_full, tx_empty, tx_full;
  logic rx_pushed, rx_popped, tx_pushed, tx_popped;
  logic [7:0] rx_dout;

  assign rx_ready = mode_q[MODE_FIFO] && !inhibit_rx && !rx_full && !flush;
  assign tx_valid = mode_q[MODE_FIFO] && !inhibit_tx && !tx_empty && !flush;

  sfx_fifo #(.W(8), .DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_ni), .flush(flush),
    .push(rx_valid && rx_ready), .din(rx_data),
    .pop(host_rd && data_fifo), .dout(rx_dout), .count(rx_cnt),
    .empty(rx_empty), .full(rx_full), .pushed(rx_pushed), .popped(rx_popped));

  sfx_fifo #(.W(8), .DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_ni), .flush(flush),
    .push(host_wr && data_fifo), .din(host_wdata),
    .pop(tx_valid && tx_ready), .dout(tx_data), .count(tx_cnt),
    .empty(tx_empty), .full(tx_full), .pushed(tx_pushed), .popped(tx_popped));

  logic [NSRC-1:0] pend;
  sfx_irq #(.DEPTH(DEPTH), .CTO_CYCLES(CTO_CYCLES)) u_irq (
    .clk(clk), .rst_n(rst_ni),
    .rx_cnt(rx_cnt), .rx_pushed(rx_pushed), .rx_popped(rx_popped),
    .tx_cnt(tx_cnt), .tx_pushed(tx_pushed), .tx_popped(tx_popped),
    .flush(flush), .stat_rd(stat_rd), .timer_irq(timer_irq),
    .tmr_en(tctl_q), .tmr_off(tmr_off), .ier(ier_q[NSRC-1:0]),
    .level_mode(mode_q[MODE_LEVEL]), .pend(pend), .irq_out(irq_out));

  // register next state
  always_comb begin
    mode_d = mode_q;
    ier_d  = ier_q;
    tivl_d = tivl_q;
    tctl_d = tctl_q;
    if (ext_wr) begin
      case (sub)
        OFF_MODE: mode_d = host_wdata & MODE_WMASK;
        OFF_IER:  ier_d  = host_wdata & IER_WMASK;
        OFF_TIVL: tivl_d = host_wdata;
        OFF_TCTL: tctl_d = host_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ier_q  <= '0;
      tivl_q <= '0;
      tctl_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ier_q  <= ier_d;
      tivl_q <= tivl_d;
      tctl_q <= tctl_d;
    end
  end

  // read path
  logic [7:0] status;
  assign status = {pend[SRC_TMR], pend[SRC_CTO], !rx_full, (rx_cnt >= CW'(HALF)),
                   rx_empty, tx_full, (tx_cnt >= CW'(HALF)), tx_empty};

  always_comb begin
    host_rdata = '0;
    if (core_sel) begin
      if (data_fifo) host_rdata = rx_empty ? 8'h00 : rx_dout;
      else           host_rdata = core_rdata;
    end else begin
      case (sub)
        OFF_MODE: host_rdata = mode_q;
        OFF_IER:  host_rdata = ier_q;
        OFF_STAT: host_rdata = status;
        OFF_TIVL: host_rdata = tivl_q;
        OFF_TCTL: host_rdata = {7'b0, tctl_q};
        default:  host_rdata = '0;
      endcase
    end
  end

  assign tmr_interval = tivl_q;
  assign tmr_enable   = tctl_q;
  assign flow_auto    = mode_q[MODE_FLOW];
endmodule

// File: rtl/sfx_ctrl_chk.sv
module sfx_ctrl_chk (
  input logic       clk,
  input logic       rst_ni,
  input logic       inhibit_rx,
  input logic       inhibit_tx,
  input logic       rx_ready,
  input logic       tx_valid,
  input logic       irq_out,
  input logic       host_wr,
  input logic       flush,
  input logic       rx_fifo_empty,
  input logic       tx_fifo_empty,
  input logic [7:0] mode_q,
  input logic [7:0] ier_q
);
  p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    inhibit_rx |-> !rx_ready);

  p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    inhibit_tx |-> !tx_valid);

  p_tx_source_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    tx_valid |-> !tx_fifo_empty);

  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    flush |=> (rx_fifo_empty && tx_fifo_empty));

  p_edge_pulse_r13: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_out && !mode_q[4] && !host_wr) |=> !irq_out);

  p_quiet_r13: assert property (@(posedge clk) disable iff (!rst_ni)
    (ier_q == 8'h00 && $past(ier_q) == 8'h00) |-> !irq_out);
endmodule

bind sfx_ctrl sfx_ctrl_chk u_chk (
  .clk(clk), .rst_ni(rst_ni), .inhibit_rx(inhibit_rx), .inhibit_tx(inhibit_tx),
  .rx_ready(rx_ready), .tx_valid(tx_valid), .irq_out(irq_out), .host_wr(host_wr),
  .flush(flush), .rx_fifo_empty(rx_empty), .tx_fifo_empty(tx_empty),
  .mode_q(mode_q), .ier_q(ier_q));

// File: tb/sfx_ctrl_bench.sv
`timescale 1ns/1ps
module sfx_ctrl_bench;
  localparam int CTO = 4096;

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic host_wr, host_rd, irq_out;
  logic [2:0] core_addr;
  logic [7:0] core_wdata, core_rdata;
  logic core_wr, core_rd;
  logic rx_valid, rx_ready, tx_valid, tx_ready;
  logic [7:0] rx_data, tx_data;
  logic inhibit_rx, inhibit_tx, timer_irq;
  logic [7:0] tmr_interval;
  logic tmr_enable, flow_auto;

  int checks = 0;
  int fails  = 0;
  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  logic [7:0] creg [8];

  always #4 clk = ~clk;   // 125 MHz

  sfx_ctrl u_sfx_ctrl (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata), .irq_out(irq_out),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_wr(core_wr), .core_rd(core_rd),
    .core_rdata(core_rdata), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .inhibit_rx(inhibit_rx), .inhibit_tx(inhibit_tx), .timer_irq(timer_irq),
    .tmr_interval(tmr_interval), .tmr_enable(tmr_enable), .flow_auto(flow_auto));

  // simple model of the core's register file
  always @(posedge clk) if (core_wr) creg[core_addr] <= core_wdata;
  assign core_rdata = creg[core_addr];

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  // scoreboard drivers
  task automatic tx_send(input logic [7:0] b);
    host_write(4'd8, b);
    txq.push_back(b);
  endtask

  task automatic core_push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    #3;
    while (!rx_ready) begin
      @(negedge clk);
      #3;
    end
    rxq.push_back(b);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic rx_get();
    logic [7:0] d;
    host_read(4'd8, d);
    if (rxq.size() == 0) chk("R4 rx underrun", d, 8'hxx);
    else chk("R4 rx order", d, rxq.pop_front());
  endtask

  task automatic timer_pulse();
    @(negedge clk); timer_irq = 1'b1;
    @(negedge clk); timer_irq = 1'b0;
  endtask

  // tx monitor: compares every handshake against the expected queue
  always begin
    @(negedge clk);
    #3;
    if (tx_valid && tx_ready) begin
      if (txq.size() == 0) chk("R4 tx unexpected", tx_data, 8'hxx);
      else chk("R4 tx order", tx_data, txq.pop_front());
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    rst_n = 1'b0; host_addr = '0; host_wdata = '0; host_wr = 1'b0; host_rd = 1'b0;
    rx_valid = 1'b0; rx_data = '0; tx_ready = 1'b1;
    inhibit_rx = 1'b0; inhibit_tx = 1'b0; timer_irq = 1'b0;
    cyc(5);
    rst_n = 1'b1;
    cyc(4);

    // R1 reset state
    host_read(4'd2, d); chk("R1 status", d, 8'h29);
    host_read(4'd0, d); chk("R1 mode", d, 8'h00);
    host_read(4'd1, d); chk("R1 ier", d, 8'h00);
    chk("R1 irq", {7'b0, irq_out}, 8'h00);
    chk("R1 rx_ready", {7'b0, rx_ready}, 8'h00);
    chk("R1 tx_valid", {7'b0, tx_valid}, 8'h00);

    // R3 pass-through with FIFOs disabled
    host_write(4'd9, 8'h5A); cyc(1);
    chk("R3 core reg1", creg[1], 8'h5A);
    host_write(4'd12, 8'hA6);
    host_read(4'd12, d); chk("R3 core read", d, 8'hA6);
    host_write(4'd8, 8'h3C);
    host_read(4'd8, d); chk("R3 data reg to core", d, 8'h3C);

    // R2 / R6 mode fields and swap
    host_write(4'd0, 8'hFF);
    host_read(4'd8, d); chk("R2 R6 mode via swapped window", d, 8'h1D);
    chk("R2 flow_auto", {7'b0, flow_auto}, 8'h01);
    host_write(4'd1, 8'h77); cyc(1);
    chk("R6 low half reaches core", creg[1], 8'h77);
    host_write(4'd8, 8'h14);
    host_read(4'd0, d); chk("R2 mode readback", d, 8'h14);

    // R4 FIFO data path
    for (int i = 0; i < 4; i++) tx_send(8'h40 + 8'(i));
    for (int i = 0; i < 4; i++) core_push(8'h80 + 8'(i));
    for (int i = 0; i < 4; i++) rx_get();
    core_push(8'h11); core_push(8'h22);
    // R4 simultaneous core push and host pop
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h33; host_addr = 4'd8; host_rd = 1'b1;
    #1 d = host_rdata;
    chk("R4 same-cycle pop head", d, rxq.pop_front());
    #2 chk("R4 same-cycle rx_ready", {7'b0, rx_ready}, 8'h01);
    rxq.push_back(8'h33);
    @(negedge clk);
    rx_valid = 1'b0; host_rd = 1'b0;
    rx_get(); rx_get();
    host_read(4'd2, d); chk("R4 rx empty after same-cycle", d & 8'h08, 8'h08);
    cyc(4);
    chk("R4 tx drained", 8'(txq.size()), 8'h00);

    // R5 inhibits
    @(negedge clk); inhibit_rx = 1'b1; rx_valid = 1'b1; rx_data = 8'hEE;
    #3 chk("R5 rx_ready held", {7'b0, rx_ready}, 8'h00);
    @(negedge clk); rx_valid = 1'b0; inhibit_rx = 1'b0;
    inhibit_tx = 1'b1;
    tx_send(8'h5C);
    cyc(3);
    chk("R5 tx_valid held", {7'b0, tx_valid}, 8'h00);
    inhibit_tx = 1'b0;
    cyc(3);
    chk("R5 tx released", 8'(txq.size()), 8'h00);

    // R7 flush
    tx_ready = 1'b0;
    for (int i = 0; i < 5; i++) tx_send(8'h60 + 8'(i));
    for (int i = 0; i < 5; i++) core_push(8'h70 + 8'(i));
    host_write(4'd2, 8'h00);
    txq.delete(); rxq.delete();
    host_read(4'd2, d); chk("R7 status after flush", d, 8'h29);
    tx_ready = 1'b1;

    // R8 status layout and receive-half source
    host_write(4'd1, 8'h01);
    for (int i = 0; i < 128; i++) core_push(8'(i * 3));
    host_read(4'd2, d); chk("R8 status half", d, 8'h31);
    cyc(2);
    chk("R8 irq level", {7'b0, irq_out}, 8'h01);
    rx_get();
    cyc(3);
    chk("R8 irq cleared below half", {7'b0, irq_out}, 8'h00);
    for (int i = 0; i < 127; i++) rx_get();

    // R9 character time-out
    host_write(4'd1, 8'h08);
    core_push(8'hC5);
    cyc(CTO + 10);
    chk("R9 irq time-out", {7'b0, irq_out}, 8'h01);
    host_read(4'd2, d); chk("R9 pending bit", d & 8'h40, 8'h40);
    cyc(3);
    chk("R9 irq cleared", {7'b0, irq_out}, 8'h00);
    host_read(4'd2, d); chk("R9 pending cleared", d & 8'h40, 8'h00);
    rx_get();

    // R11 transmit half
    host_read(4'd2, d);
    host_write(4'd1, 8'h02);
    tx_ready = 1'b0;
    for (int i = 0; i < 128; i++) tx_send(8'(i + 7));
    host_read(4'd2, d); chk("R8 tx half flag", d & 8'h03, 8'h02);
    chk("R11 no irq at 128", {7'b0, irq_out}, 8'h00);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    cyc(3);
    chk("R11 irq after drop below half", {7'b0, irq_out}, 8'h01);
    tx_send(8'hAB);
    cyc(3);
    chk("R11 cleared by refill", {7'b0, irq_out}, 8'h00);
    tx_ready = 1'b1;
    cyc(300);
    chk("R4 long tx drained", 8'(txq.size()), 8'h00);
    host_read(4'd2, d);

    // R10 transmit empty
    host_write(4'd1, 8'h04);
    tx_ready = 1'b0;
    tx_send(8'h99);
    cyc(2);
    chk("R10 no irq while queued", {7'b0, irq_out}, 8'h00);
    tx_ready = 1'b1;
    cyc(4);
    chk("R10 irq on empty", {7'b0, irq_out}, 8'h01);
    host_read(4'd2, d);
    cyc(3);
    chk("R10 cleared by status read", {7'b0, irq_out}, 8'h00);

    // R12 timer registers and source
    host_write(4'd3, 8'h37);
    host_write(4'd4, 8'h01);
    chk("R12 interval out", tmr_interval, 8'h37);
    chk("R12 enable out", {7'b0, tmr_enable}, 8'h01);
    host_read(4'd3, d); chk("R12 interval readback", d, 8'h37);
    host_write(4'd1, 8'h10);
    timer_pulse();
    cyc(3);
    chk("R12 irq timer", {7'b0, irq_out}, 8'h01);
    host_read(4'd2, d); chk("R12 status bit7", d & 8'h80, 8'h80);
    host_write(4'd4, 8'h00);
    cyc(3);
    chk("R12 cleared by disable", {7'b0, irq_out}, 8'h00);
    host_read(4'd2, d); chk("R12 status bit7 clear", d & 8'h80, 8'h00);

    // R13 edge mode pulse
    host_write(4'd0, 8'h04);
    host_write(4'd4, 8'h01);
    timer_pulse();
    n = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (irq_out) n++;
    end
    chk("R13 single edge pulse", 8'(n), 8'h01);
    host_write(4'd4, 8'h00);

    cyc(5);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule